// File: doc/BRIEF.md
# Event-Selected Performance Counter Bank

This block holds a set of hardware performance counters for a processor core. Each counter has a select mask that picks which of fifteen core event strobes it follows. The counter itself is a register whose width is a parameter, seen by software as a low and a high 32-bit word. The core drives one-cycle event strobes together with its sleep and debug status. Software programs the masks, presets or clears the counters and gates them through a control-register port, with a single-cycle write and a combinational read.

Any selected event that fires in a cycle advances the counter by exactly one, however many selected events fire together. All counting freezes while the core sleeps or is halted in debug. One shared gating register holds one stop bit per counter. Register slots for counters that are not built stay harmless: they read zero and ignore writes.

Top module: `pcb_bank`

## Requirements
- R1: After reset every select mask, every counter word and the gating register read zero.
- R2: A counter whose mask has bit k set gains exactly 1 in each clock cycle in which event strobe k is high. Events whose mask bit is clear have no effect. The event encoding is: bit 0 active cycle, 2 any retired instruction, 3 retired compressed instruction, 4 fetch wait, 5 issue wait after flush, 6 multi-cycle ALU wait, 7 load, 8 store, 9 load/store wait, 10 unconditional jump, 11 conditional branch, 12 taken branch, 13 trap entry, 14 illegal instruction.
- R3: When several selected events fire in the same cycle, the counter gains exactly 1.
- R4: Mask bit 1 is not implemented. It reads zero after any write and never causes counting, so a full-ones write reads back as 0x7FFD.
- R5: While sleep_i or debug_i is high, no counter changes except through a software write.
- R6: Bit i of the gating register stops counter i when set and lets it count when clear. Bits for counters that are not built read zero.
- R7: An increment that overflows the low word carries into the high word in the same cycle. The counter wraps to zero at 2^CNT_W, and high-word bits at or above CNT_W read zero.
- R8: A write to either word of a counter in the same cycle as one of its selected events stores the written value, and that cycle's increment is dropped.
- R9: Select, low-word and high-word slots for counter indices at or above NUM_CNT read zero and ignore writes, and an access there raises no error.
- R10: Address bits [5:4] pick the region: 00 = select mask, 01 = low word, 10 = high word, 11 = gating register (index 0 only). Bits [3:0] pick the counter index. A write takes effect at the next clock edge, and a read returns data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 15 | One-cycle event strobes from the core |
| sleep_i | input | 1 | Core is in sleep |
| debug_i | input | 1 | Core is halted in debug |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 6 | Register address: region and counter index |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read data (combinational) |

## Verification
The main event path is tried with a single matching event, two selected events firing at once, an event whose mask bit is clear, the dead mask bit, a full mask with one event firing, and a matching event under sleep, under debug and under a set gating bit. The single event shows the basic count. Two events at once separate "OR, then one step" from "add per event". Sleep, debug and gating each suppress an event that would otherwise count, so a missing gate shows as a count of one. Directed runs preset the low word to all ones to expose the same-cycle carry and the wrap at 40 bits. Another run collides a write with an event to show which one wins. Other runs count over several cycles, drive two counters with different masks, and access an index that is not built.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    localparam int EVT_W = 15;
    localparam logic [EVT_W-1:0] EVT_IMPL = 15'h7FFD;

    localparam int EV_CYCLE   = 0;
    localparam int EV_RETIRE  = 2;
    localparam int EV_RET_C   = 3;
    localparam int EV_FETCH_W = 4;
    localparam int EV_ISSUE_W = 5;
    localparam int EV_ALU_W   = 6;
    localparam int EV_LOAD    = 7;
    localparam int EV_STORE   = 8;
    localparam int EV_LSU_W   = 9;
    localparam int EV_JUMP    = 10;
    localparam int EV_BRANCH  = 11;
    localparam int EV_TAKEN   = 12;
    localparam int EV_TRAP    = 13;
    localparam int EV_ILLEGAL = 14;

    typedef enum logic [1:0] {
        RGN_SEL  = 2'b00,
        RGN_LO   = 2'b01,
        RGN_HI   = 2'b10,
        RGN_GATE = 2'b11
    } rgn_e;
endpackage

// File: rtl/pcb_evt_sel.sv
module pcb_evt_sel
    import pcb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [EVT_W-1:0] wdata_i,
    input  logic [EVT_W-1:0] evt_i,
    output logic [EVT_W-1:0] sel_o,
    output logic             hit_o
);
    logic [EVT_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    sel_q <= '0;
        else if (we_i) sel_q <= wdata_i & EVT_IMPL;
    end

    assign sel_o = sel_q;
    assign hit_o = |(sel_q & evt_i);

    // R2: a hit always has some implemented event strobe behind it
    a_r2_hit_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((evt_i & EVT_IMPL) != '0));
    // R4: the dead mask position never holds a one
    a_r4_dead_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (sel_o[1] == 1'b0));
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter #(
    parameter int CNT_W = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        inc_i,
    input  logic        wr_lo_i,
    input  logic        wr_hi_i,
    input  logic [31:0] wdata_i,
    output logic [63:0] val_o
);
    generate
        if (CNT_W == 0) begin : g_none
            logic unused_in;
            assign unused_in = ^{inc_i, wr_lo_i, wr_hi_i, wdata_i, clk, rst_n};
            assign val_o = '0;
        end else begin : g_reg
            logic [CNT_W-1:0] cnt_q;
            logic [63:0]      full;
            logic [63:0]      nxt;

            assign full = 64'(cnt_q);

            always_comb begin
                nxt = full;
                if (wr_lo_i) nxt[31:0]  = wdata_i;
                if (wr_hi_i) nxt[63:32] = wdata_i;
                if (!wr_lo_i && !wr_hi_i && inc_i) nxt = full + 64'd1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= nxt[CNT_W-1:0];
            end

            if (CNT_W < 64) begin : g_trim
                logic unused_hi;
                assign unused_hi = ^nxt[63:CNT_W];
            end

            assign val_o = full;

            // R3: without a write, one cycle moves the count by at most one
            a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
                (!wr_lo_i && !wr_hi_i) |=>
                    (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

            if (CNT_W >= 32) begin : g_wr_chk
                // R8: a low-word write lands even if an increment was requested
                a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
                    wr_lo_i |=> (cnt_q[31:0] == $past(wdata_i)));
            end
        end
    endgenerate
endmodule

// File: rtl/pcb_bank.sv
module pcb_bank
    import pcb_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 40,
    parameter int IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [14:0]      evt_i,
    input  logic             sleep_i,
    input  logic             debug_i,
    input  logic             csr_we_i,
    input  logic [5:0]       csr_addr_i,
    input  logic [31:0]      csr_wdata_i,
    output logic [31:0]      csr_rdata_o
);
    localparam int ADDR_W = IDX_W + 2;
    localparam logic [IDX_W:0] NUM_L = (IDX_W+1)'(NUM_CNT);

    rgn_e             rgn;
    logic [IDX_W-1:0] idx;
    logic             freeze;
    logic             idx_absent;

    logic [NUM_CNT-1:0] wr_sel, wr_lo, wr_hi, hit, inc;
    logic [NUM_CNT-1:0] gate_q;
    logic [EVT_W-1:0]   sel_v [NUM_CNT];
    logic [63:0]        val_v [NUM_CNT];

    assign rgn        = rgn_e'(csr_addr_i[ADDR_W-1 -: 2]);
    assign idx        = csr_addr_i[IDX_W-1:0];
    assign freeze     = sleep_i | debug_i;
    assign idx_absent = ({1'b0, idx} >= NUM_L);

    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_q <= '0;
        else if (csr_we_i && rgn == RGN_GATE && idx == '0)
            gate_q <= csr_wdata_i[NUM_CNT-1:0];
    end

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
            assign wr_sel[i] = csr_we_i && (rgn == RGN_SEL) && (idx == IDX_W'(i));
            assign wr_lo[i]  = csr_we_i && (rgn == RGN_LO)  && (idx == IDX_W'(i));
            assign wr_hi[i]  = csr_we_i && (rgn == RGN_HI)  && (idx == IDX_W'(i));
            assign inc[i]    = hit[i] & ~gate_q[i] & ~freeze;

            pcb_evt_sel u_sel (
                .clk     (clk),
                .rst_n   (rst_n),
                .we_i    (wr_sel[i]),
                .wdata_i (csr_wdata_i[EVT_W-1:0]),
                .evt_i   (evt_i),
                .sel_o   (sel_v[i]),
                .hit_o   (hit[i])
            );

            pcb_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .inc_i   (inc[i]),
                .wr_lo_i (wr_lo[i]),
                .wr_hi_i (wr_hi[i]),
                .wdata_i (csr_wdata_i),
                .val_o   (val_v[i])
            );

            // R5: sleep or debug freezes the count when software is not writing
            a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
                (freeze && !csr_we_i) |=> $stable(val_v[i]));
            // R6: a set gating bit holds the count when software is not writing
            a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
                (gate_q[i] && !csr_we_i) |=> $stable(val_v[i]));
        end
    endgenerate

    always_comb begin
        csr_rdata_o = '0;
        case (rgn)
            RGN_GATE: if (idx == '0) csr_rdata_o = 32'(gate_q);
            default: begin
                for (int i = 0; i < NUM_CNT; i++) begin
                    if (idx == IDX_W'(i)) begin
                        case (rgn)
                            RGN_SEL: csr_rdata_o = 32'(sel_v[i]);
                            RGN_LO:  csr_rdata_o = val_v[i][31:0];
                            RGN_HI:  csr_rdata_o = val_v[i][63:32];
                            default: csr_rdata_o = '0;
                        endcase
                    end
                end
            end
        endcase
    end

    // R9: slots of counters that are not built read zero
    a_r9_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn != RGN_GATE && idx_absent) |-> (csr_rdata_o == 32'd0));
endmodule

// File: tb/pcb_bank_bench.sv
`timescale 1ns/1ps
module pcb_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [14:0] evt;
    logic        slp, dbg, we;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pcb_bank u_pcb_bank (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .sleep_i(slp), .debug_i(dbg),
        .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rdata)
    );

    localparam logic [5:0] A_SEL = 6'h00, A_LO = 6'h10, A_HI = 6'h20, A_GATE = 6'h30;

    // {mask[14:0], events[14:0], sleep, debug, gate0, expected low word}
    localparam int NV = 8;
    localparam logic [33:0] VEC [NV] = '{
        {15'h0001, 15'h0001, 1'b0, 1'b0, 1'b0, 1'b1},   // R2 single event
        {15'h0081, 15'h0081, 1'b0, 1'b0, 1'b0, 1'b1},   // R3 two at once
        {15'h0080, 15'h0100, 1'b0, 1'b0, 1'b0, 1'b0},   // R2 unselected
        {15'h0002, 15'h0002, 1'b0, 1'b0, 1'b0, 1'b0},   // R4 dead bit
        {15'h4000, 15'h4000, 1'b1, 1'b0, 1'b0, 1'b0},   // R5 sleep
        {15'h4000, 15'h4000, 1'b0, 1'b1, 1'b0, 1'b0},   // R5 debug
        {15'h1000, 15'h1000, 1'b0, 1'b0, 1'b1, 1'b0},   // R6 gated
        {15'h7FFD, 15'h2000, 1'b0, 1'b0, 1'b0, 1'b1}    // R2 full mask
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic csr_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic pulse(input logic [14:0] e, input logic s, input logic g, input int n);
        @(negedge clk); evt = e; slp = s; dbg = g;
        repeat (n) @(negedge clk);
        evt = '0; slp = 1'b0; dbg = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        rst_n = 1'b0; evt = '0; slp = 1'b0; dbg = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        csr_rd(A_LO, r);   check("R1 low word", r, 32'h0);
        csr_rd(A_HI, r);   check("R1 high word", r, 32'h0);
        csr_rd(A_SEL, r);  check("R1 mask", r, 32'h0);
        csr_rd(A_GATE, r); check("R1 gate", r, 32'h0);

        // vector walk on counter 0
        for (int v = 0; v < NV; v++) begin
            csr_wr(A_GATE, {31'b0, VEC[v][1]});
            csr_wr(A_SEL, {17'b0, VEC[v][33:19]});
            csr_wr(A_LO, 32'h0);
            csr_wr(A_HI, 32'h0);
            pulse(VEC[v][18:4], VEC[v][3], VEC[v][2], 1);
            csr_rd(A_LO, r);
            check($sformatf("R2/R3/R4/R5/R6 vector %0d", v), r, {31'b0, VEC[v][0]});
        end
        csr_wr(A_GATE, 32'h0);

        // R4 dead mask bit reads zero
        csr_wr(A_SEL, 32'hFFFF_FFFF);
        csr_rd(A_SEL, r); check("R4 mask readback", r, 32'h0000_7FFD);

        // R6 gate bits beyond built counters read zero
        csr_wr(A_GATE, 32'hFFFF_FFFF);
        csr_rd(A_GATE, r); check("R6 gate readback", r, 32'h0000_000F);
        csr_wr(A_GATE, 32'h0);

        // R9 absent counter index 5
        csr_wr(A_LO + 6'd5, 32'h1234);
        csr_wr(A_SEL + 6'd5, 32'h1);
        csr_rd(A_LO + 6'd5, r);  check("R9 absent low", r, 32'h0);
        csr_rd(A_SEL + 6'd5, r); check("R9 absent mask", r, 32'h0);

        // R7 carry, width masking and wrap
        csr_wr(A_SEL, 32'h1);
        csr_wr(A_LO, 32'hFFFF_FFFF);
        csr_wr(A_HI, 32'h0);
        pulse(15'h0001, 1'b0, 1'b0, 1);
        csr_rd(A_LO, r); check("R7 carry low", r, 32'h0);
        csr_rd(A_HI, r); check("R7 carry high", r, 32'h1);
        csr_wr(A_HI, 32'hFFFF_FFFF);
        csr_rd(A_HI, r); check("R7 high masked", r, 32'h0000_00FF);
        csr_wr(A_LO, 32'hFFFF_FFFF);
        pulse(15'h0001, 1'b0, 1'b0, 1);
        csr_rd(A_LO, r); check("R7 wrap low", r, 32'h0);
        csr_rd(A_HI, r); check("R7 wrap high", r, 32'h0);

        // R8 write collides with an event
        @(negedge clk); we = 1'b1; addr = A_LO; wdata = 32'h10; evt = 15'h0001;
        @(negedge clk); we = 1'b0; evt = '0;
        csr_rd(A_LO, r); check("R8 write wins", r, 32'h10);

        // R2 several cycles in a row
        csr_wr(A_LO, 32'h0);
        pulse(15'h0001, 1'b0, 1'b0, 5);
        csr_rd(A_LO, r); check("R2 five cycles", r, 32'h5);

        // R10 two counters with distinct masks
        csr_wr(A_SEL + 6'd1, 32'h80);
        csr_wr(A_LO + 6'd1, 32'h0);
        csr_wr(A_LO, 32'h0);
        pulse(15'h0080, 1'b0, 1'b0, 1);
        csr_rd(A_LO + 6'd1, r); check("R10 counter 1 load", r, 32'h1);
        csr_rd(A_LO, r);        check("R10 counter 0 idle", r, 32'h0);

        // R6 gate stops only its own counter
        csr_wr(A_SEL + 6'd1, 32'h1);
        csr_wr(A_LO + 6'd1, 32'h0);
        csr_wr(A_GATE, 32'h1);
        pulse(15'h0001, 1'b0, 1'b0, 1);
        csr_rd(A_LO, r);        check("R6 gated counter 0", r, 32'h0);
        csr_rd(A_LO + 6'd1, r); check("R6 open counter 1", r, 32'h1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule